// File: doc/BRIEF.md
# Aura Credit Counter with Random Early Drop

This block keeps the buffer accounting for a small table of auras. An aura is a named quota that draws buffers from one of several pools, and any number of auras may share a pool. Each aura holds a count, a ceiling (the limit) and an interrupt threshold. An allocate request through an aura is granted only while the count is under the limit, and it raises the count by one. A free lowers the count by one and never takes it below zero. Software normally sets the count equal to the limit and then hands buffers to the aura. Each buffer handed in is a free, so the count falls as the aura fills.

A packet receiver also uses the count for congestion control. Each aura has a level word that holds an enable, a shift amount, a drop level and a pass level. The count is shifted right by the shift amount, and the 8-bit result is compared with the two levels. The comparison gives one of three zones: pass, random drop or hard drop. In the random zone, an 8-bit LFSR decides the drop with a probability that grows as the scaled count moves from the pass level toward the drop level. Each aura also has a sticky interrupt flag. It is set when granted allocations carry the count up to the threshold.

Top module: `aura_red_counter`

## Requirements
- R1: After reset, every aura has count 0x1_0000_0000, limit 0xF_FFFF_FFFF, threshold 0xF_FFFF_FFFE, pool 0, an all-zero level word and a clear interrupt flag.
- R2: The register port selects an aura with regAura and a field with regField (0 pool, 1 count, 2 limit, 3 threshold, 4 level word, 5 interrupt flag at bit 0). A write takes effect at the clock edge. regRdData shows the selected field combinationally, right-aligned, with all unused bits zero.
- R3: Every event response carries the pool number of the addressed aura, and several auras may hold the same pool number.
- R4: An allocate is granted when the count is below the limit, and the grant raises the count by one. When the count is at or above the limit, the allocate is denied and the count is unchanged.
- R5: A free is always granted. It lowers the count by one, and a count of zero stays at zero.
- R6: The response to an event (respValid with grant, pool, zone and drop) appears on the clock edge that accepts the event and lasts one cycle.
- R7: The level word holds the enable at bit 38, the shift at bits 37:32, the drop level at bits 23:16 and the pass level at bits 15:8. With the enable clear, the zone is pass (code 0) and respDrop is 0.
- R8: With the enable set, let s = count >> shift. If s is at most the pass level, the zone is pass (code 0) and there is no drop. If s exceeds 255 or the drop level, the zone is hard (code 2) and respDrop is 1. Otherwise the zone is random (code 1).
- R9: In the random zone, respDrop is 1 exactly when L*(drop-pass) < (s-pass)*256. L is the LFSR value. The LFSR is 8 bits with polynomial x^8+x^6+x^5+x^4+1, shifts left with the feedback entering bit 0, starts at 0x01 after reset, and advances once per accepted event after its value has been used.
- R10: A granted allocate that carries the count from below the threshold to at or above it sets the aura's flag on intrVec. The flag stays set until a write to field 5 with bit 0 at one clears it, and a write with bit 0 at zero leaves it set.
- R11: When a count write and an event hit the same aura in the same cycle, the written value is kept. The event still gets its normal response.
- R12: Grant, zone and drop are computed from the count as it was before the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAura | input | IDX_W | Aura addressed by the register port |
| regField | input | 3 | Field select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Selected field, combinational |
| evValid | input | 1 | Alloc/free event strobe |
| evIsFree | input | 1 | 1 = free, 0 = allocate |
| evAura | input | IDX_W | Aura of the event |
| respValid | output | 1 | Response strobe |
| respGrant | output | 1 | Event granted |
| respPool | output | POOL_W | Pool mapped to the aura |
| respZone | output | 2 | 0 pass, 1 random, 2 hard |
| respDrop | output | 1 | Drop decision |
| intrVec | output | NUM_AURAS | Sticky threshold flags |

## Verification
The random zone and the threshold crossing are the hardest states to reach. Both require the count to walk through many values, and the drop decision also depends on how many events have gone by since reset. The bench therefore runs every aura through a complete fill and drain: from the limit down to zero and past it, then back up to the limit and past it. The limits and shifts differ per aura, so the band between the pass and drop levels is crossed at several scales. The bench tracks the LFSR position with its own model of the polynomial, and it forces the over-range and write-versus-event cases with direct count writes.

// File: rtl/aura_red_pkg.sv
package aura_red_pkg;

  typedef enum logic [2:0] {
    FLD_POOL   = 3'd0,
    FLD_COUNT  = 3'd1,
    FLD_LIMIT  = 3'd2,
    FLD_THRESH = 3'd3,
    FLD_LEVELS = 3'd4,
    FLD_INTR   = 3'd5
  } field_e;

  typedef enum logic [1:0] {
    ZONE_PASS   = 2'd0,
    ZONE_RANDOM = 2'd1,
    ZONE_HARD   = 2'd2
  } zone_e;

  localparam int LVL_EN_BIT = 38;
  localparam int SHIFT_LSB  = 32;
  localparam int SHIFT_W    = 6;
  localparam int DROP_LSB   = 16;
  localparam int PASS_LSB   = 8;
  localparam int LVL_W      = 8;

  typedef struct packed {
    logic               en;
    logic [SHIFT_W-1:0] shift;
    logic [LVL_W-1:0]   dropLvl;
    logic [LVL_W-1:0]   passLvl;
  } levels_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntDec;
    logic wrPool;
    logic wrCount;
    logic wrLimit;
    logic wrThresh;
    logic wrLevels;
    logic clrIntr;
  } strobe_t;

endpackage

// File: rtl/aura_dp.sv
module aura_dp
  import aura_red_pkg::*;
#(
  parameter int NUM_AURAS = 4,
  parameter int CNT_W     = 36,
  parameter int POOL_W    = 6,
  localparam int IDX_W    = (NUM_AURAS > 1) ? $clog2(NUM_AURAS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [IDX_W-1:0]     evAura,
  input  logic [IDX_W-1:0]     regAura,
  input  field_e               regField,
  input  logic [63:0]          regWrData,
  output logic [63:0]          regRdData,
  output logic [CNT_W-1:0]     evCount,
  output logic [CNT_W-1:0]     evLimit,
  output levels_t              evLevels,
  output logic [POOL_W-1:0]    evPool,
  output logic [NUM_AURAS-1:0] intrVec
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(64'h1_0000_0000);
  localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(64'hF_FFFF_FFFF);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(64'hF_FFFF_FFFE);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0]  cntQ  [NUM_AURAS];
  logic [CNT_W-1:0]  limQ  [NUM_AURAS];
  logic [CNT_W-1:0]  thrQ  [NUM_AURAS];
  logic [POOL_W-1:0] poolQ [NUM_AURAS];
  levels_t           lvlQ  [NUM_AURAS];
  logic [NUM_AURAS-1:0] intrQ;

  logic [NUM_AURAS-1:0] hitWr, hitEv, setIntr, clrIntr;
  logic [CNT_W-1:0] incCnt, decCnt;
  levels_t wrLevels;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;

  assign evCount  = cntQ[evAura];
  assign evLimit  = limQ[evAura];
  assign evLevels = lvlQ[evAura];
  assign evPool   = poolQ[evAura];
  assign intrVec  = intrQ;

  assign incCnt = evCount + ONE;
  assign decCnt = (evCount == '0) ? '0 : evCount - ONE;

  assign wrLevels.en      = regWrData[LVL_EN_BIT];
  assign wrLevels.shift   = regWrData[SHIFT_LSB +: SHIFT_W];
  assign wrLevels.dropLvl = regWrData[DROP_LSB +: LVL_W];
  assign wrLevels.passLvl = regWrData[PASS_LSB +: LVL_W];

  always_comb begin
    for (int a = 0; a < NUM_AURAS; a++) begin
      hitWr[a]   = (regAura == IDX_W'(a));
      hitEv[a]   = (evAura == IDX_W'(a));
      setIntr[a] = hitEv[a] && strb.cntInc && !(hitWr[a] && strb.wrCount) &&
                   (evCount < thrQ[a]) && (incCnt >= thrQ[a]);
      clrIntr[a] = hitWr[a] && strb.clrIntr && regWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_AURAS; a++) begin
        cntQ[a]  <= CNT_RST;
        limQ[a]  <= LIM_RST;
        thrQ[a]  <= THR_RST;
        poolQ[a] <= '0;
        lvlQ[a]  <= '0;
      end
      intrQ <= '0;
    end else begin
      for (int a = 0; a < NUM_AURAS; a++) begin
        if (hitWr[a] && strb.wrCount)       cntQ[a] <= regWrData[CNT_W-1:0];
        else if (hitEv[a] && strb.cntInc)   cntQ[a] <= incCnt;
        else if (hitEv[a] && strb.cntDec)   cntQ[a] <= decCnt;
        if (hitWr[a] && strb.wrLimit)  limQ[a]  <= regWrData[CNT_W-1:0];
        if (hitWr[a] && strb.wrThresh) thrQ[a]  <= regWrData[CNT_W-1:0];
        if (hitWr[a] && strb.wrPool)   poolQ[a] <= regWrData[POOL_W-1:0];
        if (hitWr[a] && strb.wrLevels) lvlQ[a]  <= wrLevels;
        intrQ[a] <= setIntr[a] | (intrQ[a] & ~clrIntr[a]);
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regField)
      FLD_POOL:   regRdData[POOL_W-1:0] = poolQ[regAura];
      FLD_COUNT:  regRdData[CNT_W-1:0]  = cntQ[regAura];
      FLD_LIMIT:  regRdData[CNT_W-1:0]  = limQ[regAura];
      FLD_THRESH: regRdData[CNT_W-1:0]  = thrQ[regAura];
      FLD_LEVELS: begin
        regRdData[LVL_EN_BIT]            = lvlQ[regAura].en;
        regRdData[SHIFT_LSB +: SHIFT_W]  = lvlQ[regAura].shift;
        regRdData[DROP_LSB +: LVL_W]     = lvlQ[regAura].dropLvl;
        regRdData[PASS_LSB +: LVL_W]     = lvlQ[regAura].passLvl;
      end
      FLD_INTR:   regRdData[0] = intrQ[regAura];
      default:    regRdData = '0;
    endcase
  end

  for (genvar a = 0; a < NUM_AURAS; a++) begin : g_chk
    // R4/R5: without a count write, the count moves by at most one per cycle
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
      !$past(hitWr[a] && strb.wrCount) |->
        (cntQ[a] == $past(cntQ[a]) || cntQ[a] == $past(cntQ[a]) + ONE ||
         cntQ[a] == $past(cntQ[a]) - ONE));
    // R4: a rise in the count only happens from below the limit
    p_inc_below_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(hitWr[a] && strb.wrCount) && cntQ[a] == $past(cntQ[a]) + ONE) |->
        $past(cntQ[a]) < $past(limQ[a]));
    // R5: a free at zero leaves zero
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
      $past(cntQ[a] == '0 && hitEv[a] && strb.cntDec && !(hitWr[a] && strb.wrCount)) |->
        cntQ[a] == '0);
    // R10: flag holds unless cleared
    p_intr_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
      ($past(intrQ[a]) && !$past(clrIntr[a])) |-> intrQ[a]);
  end

endmodule

// File: rtl/aura_ctl.sv
module aura_ctl
  import aura_red_pkg::*;
#(
  parameter int CNT_W  = 36,
  parameter int POOL_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  field_e            regField,
  input  logic              evValid,
  input  logic              evIsFree,
  input  logic [CNT_W-1:0]  evCount,
  input  logic [CNT_W-1:0]  evLimit,
  input  levels_t           evLevels,
  input  logic [POOL_W-1:0] evPool,
  output strobe_t           strb,
  output logic              respValid,
  output logic              respGrant,
  output logic [POOL_W-1:0] respPool,
  output zone_e             respZone,
  output logic              respDrop
);

  localparam logic [7:0] LFSR_SEED = 8'h01;

  logic [7:0]       lfsrQ;
  logic             lfsrFb;
  logic [CNT_W-1:0] scaledFull;
  logic             overRange;
  logic [7:0]       scaled, diff, span;
  logic [15:0]      weighted;
  logic             randHit, allocOk, grant, dropNow;
  zone_e            zone;

  assign lfsrFb     = lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3];
  assign scaledFull = evCount >> evLevels.shift;
  assign overRange  = |scaledFull[CNT_W-1:8];
  assign scaled     = scaledFull[7:0];
  assign diff       = scaled - evLevels.passLvl;
  assign span       = evLevels.dropLvl - evLevels.passLvl;
  assign weighted   = {8'h00, lfsrQ} * {8'h00, span};
  assign randHit    = weighted < {diff, 8'h00};

  always_comb begin
    if (!evLevels.en)                                     zone = ZONE_PASS;
    else if (!overRange && scaled <= evLevels.passLvl)    zone = ZONE_PASS;
    else if (overRange || scaled > evLevels.dropLvl)      zone = ZONE_HARD;
    else                                                  zone = ZONE_RANDOM;
  end

  always_comb begin
    case (zone)
      ZONE_HARD:   dropNow = 1'b1;
      ZONE_RANDOM: dropNow = randHit;
      default:     dropNow = 1'b0;
    endcase
  end

  assign allocOk = evCount < evLimit;
  assign grant   = evIsFree | allocOk;

  always_comb begin
    strb          = '0;
    strb.cntInc   = evValid && !evIsFree && allocOk;
    strb.cntDec   = evValid && evIsFree;
    strb.wrPool   = regWrEn && (regField == FLD_POOL);
    strb.wrCount  = regWrEn && (regField == FLD_COUNT);
    strb.wrLimit  = regWrEn && (regField == FLD_LIMIT);
    strb.wrThresh = regWrEn && (regField == FLD_THRESH);
    strb.wrLevels = regWrEn && (regField == FLD_LEVELS);
    strb.clrIntr  = regWrEn && (regField == FLD_INTR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ     <= LFSR_SEED;
      respValid <= 1'b0;
      respGrant <= 1'b0;
      respPool  <= '0;
      respZone  <= ZONE_PASS;
      respDrop  <= 1'b0;
    end else begin
      respValid <= evValid;
      if (evValid) begin
        lfsrQ     <= {lfsrQ[6:0], lfsrFb};
        respGrant <= grant;
        respPool  <= evPool;
        respZone  <= zone;
        respDrop  <= dropNow;
      end
    end
  end

  // R9: the LFSR never locks up at zero
  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rstN) lfsrQ != 8'h00);
  // R6: a response strobe follows an accepted event
  p_resp_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(evValid));
  // R8: pass zone never drops, hard zone always drops
  p_pass_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respZone == ZONE_PASS) |-> !respDrop);
  p_hard_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respZone == ZONE_HARD) |-> respDrop);
  // R5: a free is always granted
  p_free_granted_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(evValid && evIsFree) |-> respGrant);

endmodule

// File: rtl/aura_red_counter.sv
module aura_red_counter
  import aura_red_pkg::*;
#(
  parameter int NUM_AURAS = 4,
  parameter int CNT_W     = 36,
  parameter int POOL_W    = 6,
  localparam int IDX_W    = (NUM_AURAS > 1) ? $clog2(NUM_AURAS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IDX_W-1:0]     regAura,
  input  logic [2:0]           regField,
  input  logic                 regWrEn,
  input  logic [63:0]          regWrData,
  output logic [63:0]          regRdData,
  input  logic                 evValid,
  input  logic                 evIsFree,
  input  logic [IDX_W-1:0]     evAura,
  output logic                 respValid,
  output logic                 respGrant,
  output logic [POOL_W-1:0]    respPool,
  output logic [1:0]           respZone,
  output logic                 respDrop,
  output logic [NUM_AURAS-1:0] intrVec
);

  strobe_t           strb;
  field_e            fieldSel;
  logic [CNT_W-1:0]  evCount, evLimit;
  levels_t           evLevels;
  logic [POOL_W-1:0] evPool;
  zone_e             zoneQ;

  assign fieldSel = field_e'(regField);
  assign respZone = zoneQ;

  aura_ctl #(.CNT_W(CNT_W), .POOL_W(POOL_W)) i_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regField(fieldSel),
    .evValid(evValid), .evIsFree(evIsFree), .evCount(evCount), .evLimit(evLimit),
    .evLevels(evLevels), .evPool(evPool), .strb(strb), .respValid(respValid),
    .respGrant(respGrant), .respPool(respPool), .respZone(zoneQ), .respDrop(respDrop)
  );

  aura_dp #(.NUM_AURAS(NUM_AURAS), .CNT_W(CNT_W), .POOL_W(POOL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evAura(evAura), .regAura(regAura),
    .regField(fieldSel), .regWrData(regWrData), .regRdData(regRdData),
    .evCount(evCount), .evLimit(evLimit), .evLevels(evLevels), .evPool(evPool),
    .intrVec(intrVec)
  );

endmodule

// File: tb/test_aura_red_counter.sv
module test_aura_red_counter;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NA = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAura = '0;
  logic [2:0]  regField = '0;
  logic        regWrEn = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        evValid = 1'b0, evIsFree = 1'b0;
  logic [1:0]  evAura = '0;
  logic        respValid, respGrant, respDrop;
  logic [5:0]  respPool;
  logic [1:0]  respZone;
  logic [NA-1:0] intrVec;

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  longint mCnt[NA], mLim[NA], mThr[NA];
  int mPool[NA], mSh[NA], mDrop[NA], mPass[NA];
  bit mEn[NA], mIntr[NA];
  bit [7:0] mLfsr;

  always #2.5 clk = ~clk;

  aura_red_counter i_aura_red_counter (
    .clk(clk), .rstN(rstN), .regAura(regAura), .regField(regField), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evValid(evValid), .evIsFree(evIsFree),
    .evAura(evAura), .respValid(respValid), .respGrant(respGrant), .respPool(respPool),
    .respZone(respZone), .respDrop(respDrop), .intrVec(intrVec)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] lfsrNext(input bit [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  function automatic longint packIntr();
    longint r = 0;
    for (int a = 0; a < NA; a++) if (mIntr[a]) r |= (64'd1 << a);
    return r;
  endfunction

  function automatic void expZone(input int a, output int z, output bit d);
    longint sc = mCnt[a] >> mSh[a];
    if (!mEn[a] || sc <= mPass[a]) begin z = 0; d = 0; end
    else if (sc > mDrop[a]) begin z = 2; d = 1; end
    else begin
      z = 1;
      d = (longint'(mLfsr) * (mDrop[a] - mPass[a])) < ((sc - mPass[a]) * 256);
    end
  endfunction

  task automatic regWrite(input int a, input int f, input longint d);
    @(negedge clk);
    regAura = 2'(a); regField = 3'(f); regWrData = 64'(d); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input int a, input int f, input longint exp, input string req);
    @(negedge clk);
    regAura = 2'(a); regField = 3'(f);
    #1;
    chk(req, regRdData, exp);
  endtask

  function automatic longint lvlWord(input int a);
    return (longint'(mEn[a]) << 38) | (longint'(mSh[a]) << 32) |
           (longint'(mDrop[a]) << 16) | (longint'(mPass[a]) << 8);
  endfunction

  task automatic doEvent(input int a, input bit isFree);
    bit expG, d; int z; string zt;
    expG = isFree ? 1'b1 : (mCnt[a] < mLim[a]);
    expZone(a, z, d);
    zt = mEn[a] ? "R8" : "R7";
    @(negedge clk);
    evValid = 1'b1; evIsFree = isFree; evAura = 2'(a);
    @(negedge clk);
    evValid = 1'b0;
    if (!isFree && expG) begin
      if (mCnt[a] < mThr[a] && mCnt[a] + 1 >= mThr[a]) mIntr[a] = 1;
      mCnt[a]++;
    end else if (isFree && mCnt[a] != 0) mCnt[a]--;
    mLfsr = lfsrNext(mLfsr);
    chk("R6 respValid", respValid, 1);
    chk(isFree ? "R5 grant" : "R4 grant", respGrant, expG);
    chk("R3 pool", respPool, mPool[a]);
    chk({zt, " zone"}, respZone, z);
    chk(z == 1 ? "R9 drop" : "R8 drop", respDrop, d);
    chk("R10 intrVec", intrVec, packIntr());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    longint lims[NA] = '{20, 40, 600, 300};
    int pools[NA] = '{5, 9, 5, 33};
    for (int a = 0; a < NA; a++) begin
      mCnt[a] = 64'h1_0000_0000; mLim[a] = 64'hF_FFFF_FFFF; mThr[a] = 64'hF_FFFF_FFFE;
      mPool[a] = 0; mEn[a] = 0; mSh[a] = 0; mDrop[a] = 0; mPass[a] = 0; mIntr[a] = 0;
    end
    mLfsr = 8'h01;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset values
    regCheck(1, 1, 64'h1_0000_0000, "R1 count");
    regCheck(1, 2, 64'hF_FFFF_FFFF, "R1 limit");
    regCheck(3, 3, 64'hF_FFFF_FFFE, "R1 thresh");
    regCheck(2, 0, 0, "R1 pool");
    regCheck(0, 4, 0, "R1 levels");
    regCheck(0, 5, 0, "R1 intr");
    #1 chk("R1 respValid", respValid, 0);

    // configure each aura; R2 readback
    for (int a = 0; a < NA; a++) begin
      longint bufs = lims[a];
      int sh = 0;
      while ((lims[a] >> sh) > 255) sh++;
      mSh[a] = sh;
      mDrop[a] = int'((lims[a] - bufs / 20) >> sh);
      mPass[a] = int'((lims[a] - (bufs * 3) / 20) >> sh);
      mEn[a] = (a != 3);
      mLim[a] = lims[a]; mThr[a] = lims[a] - 3; mCnt[a] = lims[a]; mPool[a] = pools[a];
      regWrite(a, 0, mPool[a]);
      regWrite(a, 2, mLim[a]);
      regWrite(a, 3, mThr[a]);
      regWrite(a, 4, lvlWord(a));
      regWrite(a, 1, mCnt[a]);
      regCheck(a, 0, mPool[a], "R2 pool");
      regCheck(a, 2, mLim[a], "R2 limit");
      regCheck(a, 3, mThr[a], "R2 thresh");
      regCheck(a, 4, lvlWord(a), "R2 levels R7 layout");
      regCheck(a, 1, mCnt[a], "R2 count");
    end

    // full drain and refill of each aura (R4 R5 R8 R9 R10 R12)
    for (int a = 0; a < NA; a++) begin
      for (longint i = 0; i <= lims[a]; i++) doEvent(a, 1'b1);
      regCheck(a, 1, 0, "R5 saturated count");
      for (longint i = 0; i <= lims[a]; i++) doEvent(a, 1'b0);
      regCheck(a, 1, mLim[a], "R4 count held at limit");
      regCheck(a, 5, 1, "R10 flag set");
      regWrite(a, 5, 0);
      regCheck(a, 5, 1, "R10 zero write keeps flag");
      regWrite(a, 5, 1); mIntr[a] = 0;
      regCheck(a, 5, 0, "R10 flag cleared");
      #1 chk("R10 intrVec after clear", intrVec, packIntr());
    end

    // R8: scaled count above 255 is hard drop
    mEn[0] = 1; mSh[0] = 0; mDrop[0] = 250; mPass[0] = 200;
    regWrite(0, 4, lvlWord(0));
    regWrite(0, 1, 300); mCnt[0] = 300;
    doEvent(0, 1'b0);
    doEvent(0, 1'b1);
    regCheck(0, 1, 299, "R5 decrement");

    // R11: count write beats a free on the same aura
    begin
      int z; bit d;
      expZone(1, z, d);
      @(negedge clk);
      evValid = 1'b1; evIsFree = 1'b1; evAura = 2'd1;
      regAura = 2'd1; regField = 3'd1; regWrData = 64'd7; regWrEn = 1'b1;
      @(negedge clk);
      evValid = 1'b0; regWrEn = 1'b0;
      mCnt[1] = 7; mLfsr = lfsrNext(mLfsr);
      chk("R11 respValid", respValid, 1);
      chk("R11 grant", respGrant, 1);
      chk("R11 zone", respZone, z);
      regCheck(1, 1, 7, "R11 written count kept");
    end
    doEvent(1, 1'b0);
    regCheck(1, 1, 8, "R4 increment");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule